// File: doc/BRIEF.md
# Addressed Two-Frame Serial Display Loader

This block takes display and configuration data from a host over a three-wire serial link made of a chip-enable line, a serial clock and a data line. The three inputs are asynchronous to the system clock. The block synchronises them and finds the edges of the serial clock and of chip-enable in the system clock domain. Before each burst, the host shifts an 8-bit device address while chip-enable is low. It then raises chip-enable and shifts a 56-bit frame.

The frame is assembled in a shadow register. When chip-enable falls, the frame is written to the live registers in one cycle, provided that the address matched and exactly 56 bits arrived. The last bit of the frame is a direction bit. It selects which half of the 88-bit segment image the 44 data bits replace. Only the lower-half frame carries the configuration field: standby, segment blanking, bias select and the count of segment pins taken over as plain output ports. A panel with 44 segments or fewer needs only the lower-half frame. A full panel needs both frames, 112 bits in all.

The real power-up contents are undefined. Here, reset clears everything to zero so that a display held off during loading starts from a known image.

Top module: `seg_frame_loader`

## Requirements
- R1: The address is the 8 bits sampled on rising serial-clock edges while chip-enable is low, received bit 0 first. The block accepts only the value 0x44. After any other address, the frame that follows changes no output and raises no update pulse.
- R2: Payload bits are sampled on rising serial-clock edges while chip-enable is high, received bit 0 first. A frame with fewer or more than 56 bits is discarded and leaves every output unchanged.
- R3: When payload bit 55 (the direction bit, sent last) is 0, payload bits 43..0 replace disp_o[43:0], with the first bit received going to disp_o[0]. disp_o[87:44] is unchanged.
- R4: When payload bit 55 is 1, payload bits 43..0 replace disp_o[87:44], with the first bit received going to disp_o[44]. disp_o[43:0] and all configuration outputs are unchanged.
- R5: A frame with direction 0 also loads the configuration outputs: payload bit 45 to standby_o, bit 46 to seg_off_o, bit 47 to half_bias_o, bit 48 to port_cnt_o[0], bit 49 to port_cnt_o[1] and bit 50 to port_cnt_o[2]. Bits 44 and 51..54 are fixed zeros and are ignored.
- R6: A valid frame is committed on the falling edge of chip-enable. All outputs change on the third system-clock edge after chip-enable falls. In the cycle that follows that edge, update_o is high for exactly one cycle. Outside a commit, no output changes.
- R7: After reset, disp_o, all configuration outputs and update_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sce_i | input | 1 | Serial chip-enable, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| disp_o | output | 88 | Segment image; bit n is segment data n+1 |
| standby_o | output | 1 | Power-save request |
| seg_off_o | output | 1 | Forces all segments to the off waveform |
| half_bias_o | output | 1 | 1 selects half bias, 0 selects third bias |
| port_cnt_o | output | 3 | Number of low segment pins used as plain outputs |
| update_o | output | 1 | One-cycle pulse when a frame is committed |

## Verification
The assertions assume that the serial inputs change slowly compared with the system clock. Each level of the serial clock and of chip-enable must last at least three system clocks, and chip-enable must stay low for several cycles after it falls, so that each serial edge is seen exactly once. The stimulus holds every serial level for three system clocks and never moves chip-enable and the serial clock together. A behavioural model in the bench schedules each expected commit three edges after the chip-enable drop and compares every output on every clock. Wrong and bit-reversed addresses, short and long frames, and both directions are all driven.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  localparam int ADDR_BITS  = 8;
  localparam int FRAME_BITS = 56;
  localparam int HALF_BITS  = 44;
  localparam logic [7:0] DEV_ADDR = 8'h44;

  typedef struct packed {
    logic       standby;
    logic       seg_off;
    logic       half_bias;
    logic [2:0] port_cnt;
  } cfg_t;
endpackage

// File: rtl/serial_front.sv
module serial_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sce_i,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic ce_lvl_o,
  output logic ce_rise_o,
  output logic ce_fall_o,
  output logic sclk_rise_o,
  output logic data_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] ce_q, ck_q, dt_q;
  logic         ce_d, ck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= '0;
      ck_q <= '0;
      dt_q <= '0;
      ce_d <= 1'b0;
      ck_d <= 1'b0;
    end else begin
      ce_q <= {ce_q[TOP-1:0], sce_i};
      ck_q <= {ck_q[TOP-1:0], sclk_i};
      dt_q <= {dt_q[TOP-1:0], sdata_i};
      ce_d <= ce_q[TOP];
      ck_d <= ck_q[TOP];
    end
  end

  assign ce_lvl_o    = ce_q[TOP];
  assign ce_rise_o   = ce_q[TOP] & ~ce_d;
  assign ce_fall_o   = ~ce_q[TOP] & ce_d;
  assign sclk_rise_o = ck_q[TOP] & ~ck_d;
  assign data_o      = dt_q[TOP];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int             ADDR_BITS  = 8,
  parameter int             FRAME_BITS = 56,
  parameter logic [ADDR_BITS-1:0] DEV_ADDR = 8'h44
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_lvl_i,
  input  logic                  ce_rise_i,
  input  logic                  sclk_rise_i,
  input  logic                  data_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  frame_ok_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic [ADDR_BITS-1:0]  addr_q;
  logic [FRAME_BITS-1:0] shadow_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      shadow_q <= '0;
      cnt_q    <= '0;
      hit_q    <= 1'b0;
    end else if (ce_rise_i) begin
      hit_q <= (addr_q == DEV_ADDR);
      cnt_q <= '0;
    end else if (sclk_rise_i) begin
      if (!ce_lvl_i) begin
        addr_q <= {data_i, addr_q[ADDR_BITS-1:1]};
      end else if (cnt_q <= FULL) begin
        // saturate one past full so overlong frames are flagged
        if (cnt_q < FULL) shadow_q <= {data_i, shadow_q[FRAME_BITS-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame_o    = shadow_q;
  assign frame_ok_o = hit_q && (cnt_q == FULL);
endmodule

// File: rtl/frame_commit.sv
module frame_commit
  import seg_loader_pkg::*;
#(
  parameter int FRAME_BITS = 56,
  parameter int HALF_BITS  = 44
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ce_fall_i,
  input  logic                   frame_ok_i,
  input  logic [FRAME_BITS-1:0]  frame_i,
  output logic [2*HALF_BITS-1:0] disp_o,
  output cfg_t                   cfg_o,
  output logic                   update_o
);
  localparam int DISP_BITS = 2 * HALF_BITS;
  localparam int POS_BU    = HALF_BITS + 1;
  localparam int POS_SC    = HALF_BITS + 2;
  localparam int POS_DR    = HALF_BITS + 3;
  localparam int POS_P2    = HALF_BITS + 4;
  localparam int POS_P1    = HALF_BITS + 5;
  localparam int POS_P0    = HALF_BITS + 6;
  localparam int POS_DIR   = FRAME_BITS - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_o   <= '0;
      cfg_o    <= '0;
      update_o <= 1'b0;
    end else begin
      update_o <= 1'b0;
      if (ce_fall_i && frame_ok_i) begin
        update_o <= 1'b1;
        if (frame_i[POS_DIR]) begin
          disp_o[DISP_BITS-1:HALF_BITS] <= frame_i[HALF_BITS-1:0];
        end else begin
          disp_o[HALF_BITS-1:0] <= frame_i[HALF_BITS-1:0];
          cfg_o.standby   <= frame_i[POS_BU];
          cfg_o.seg_off   <= frame_i[POS_SC];
          cfg_o.half_bias <= frame_i[POS_DR];
          cfg_o.port_cnt  <= {frame_i[POS_P0], frame_i[POS_P1], frame_i[POS_P2]};
        end
      end
    end
  end
endmodule

// File: rtl/seg_frame_loader.sv
module seg_frame_loader
  import seg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = seg_loader_pkg::ADDR_BITS,
  parameter int FRAME_W     = seg_loader_pkg::FRAME_BITS,
  parameter int HALF_W      = seg_loader_pkg::HALF_BITS,
  parameter logic [ADDR_W-1:0] ADDR = seg_loader_pkg::DEV_ADDR
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sce_i,
  input  logic                sclk_i,
  input  logic                sdata_i,
  output logic [2*HALF_W-1:0] disp_o,
  output logic                standby_o,
  output logic                seg_off_o,
  output logic                half_bias_o,
  output logic [2:0]          port_cnt_o,
  output logic                update_o
);
  logic ce_lvl, ce_rise, ce_fall, sclk_rise, sdat;
  logic [FRAME_W-1:0] frame;
  logic frame_ok;
  cfg_t cfg;

  serial_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .sce_i, .sclk_i, .sdata_i,
    .ce_lvl_o(ce_lvl), .ce_rise_o(ce_rise), .ce_fall_o(ce_fall),
    .sclk_rise_o(sclk_rise), .data_o(sdat)
  );

  frame_shifter #(.ADDR_BITS(ADDR_W), .FRAME_BITS(FRAME_W), .DEV_ADDR(ADDR)) u_shift (
    .clk_i, .rst_ni,
    .ce_lvl_i(ce_lvl), .ce_rise_i(ce_rise), .sclk_rise_i(sclk_rise), .data_i(sdat),
    .frame_o(frame), .frame_ok_o(frame_ok)
  );

  frame_commit #(.FRAME_BITS(FRAME_W), .HALF_BITS(HALF_W)) u_commit (
    .clk_i, .rst_ni,
    .ce_fall_i(ce_fall), .frame_ok_i(frame_ok), .frame_i(frame),
    .disp_o, .cfg_o(cfg), .update_o
  );

  assign standby_o   = cfg.standby;
  assign seg_off_o   = cfg.seg_off;
  assign half_bias_o = cfg.half_bias;
  assign port_cnt_o  = cfg.port_cnt;
endmodule

// File: rtl/seg_frame_loader_chk.sv
module seg_frame_loader_chk #(
  parameter int HALF_W = 44
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sce_i,
  input logic [2*HALF_W-1:0] disp_o,
  input logic                standby_o,
  input logic                seg_off_o,
  input logic                half_bias_o,
  input logic [2:0]          port_cnt_o,
  input logic                update_o
);
  logic [5:0] cfg;
  assign cfg = {standby_o, seg_off_o, half_bias_o, port_cnt_o};

  AST_DISP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable(disp_o)); // R6
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable(cfg)); // R5
  AST_ONE_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> ($stable(disp_o[HALF_W-1:0]) || $stable(disp_o[2*HALF_W-1:HALF_W]))); // R3
  AST_UPPER_KEEPS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o && !$stable(disp_o[2*HALF_W-1:HALF_W])) |-> $stable(cfg)); // R4
  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o); // R6
  AST_COMMIT_CE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> !sce_i); // R6
endmodule

bind seg_frame_loader seg_frame_loader_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sce_i(sce_i), .disp_o(disp_o),
  .standby_o(standby_o), .seg_off_o(seg_off_o), .half_bias_o(half_bias_o),
  .port_cnt_o(port_cnt_o), .update_o(update_o)
);

// File: tb/seg_frame_loader_tb.sv
module seg_frame_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sce = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [87:0] disp;
  logic standby, seg_off, half_bias, update;
  logic [2:0] port_cnt;

  int total = 0, bad = 0, cycles = 0;

  logic [87:0] m_disp = '0;
  logic [5:0]  m_cfg = '0;
  logic        m_upd = 1'b0;
  int          pend_dly = 0;
  logic [87:0] p_disp;
  logic [5:0]  p_cfg;

  always #10 clk = ~clk;

  seg_frame_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sce_i(sce), .sclk_i(sclk), .sdata_i(sdata),
    .disp_o(disp), .standby_o(standby), .seg_off_o(seg_off), .half_bias_o(half_bias),
    .port_cnt_o(port_cnt), .update_o(update)
  );

  always @(posedge clk) begin
    cycles++;
    m_upd = 1'b0;
    if (pend_dly > 0) begin
      pend_dly--;
      if (pend_dly == 0) begin
        m_disp = p_disp;
        m_cfg  = p_cfg;
        m_upd  = 1'b1;
      end
    end
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles exp <= 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check_all(input string tag);
    logic [5:0] cfg;
    cfg = {standby, seg_off, half_bias, port_cnt};
    total++;
    if (disp !== m_disp || cfg !== m_cfg || update !== m_upd) begin
      bad++;
      $display("FAIL %s: got disp=%h cfg=%b upd=%b exp disp=%h cfg=%b upd=%b",
               tag, disp, cfg, update, m_disp, m_cfg, m_upd);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      total += 4;
      if (disp[43:0] !== m_disp[43:0]) begin
        bad++; $display("FAIL R3: lower got %h exp %h", disp[43:0], m_disp[43:0]);
      end
      if (disp[87:44] !== m_disp[87:44]) begin
        bad++; $display("FAIL R4: upper got %h exp %h", disp[87:44], m_disp[87:44]);
      end
      if ({standby, seg_off, half_bias, port_cnt} !== m_cfg) begin
        bad++; $display("FAIL R5: cfg got %b exp %b", {standby, seg_off, half_bias, port_cnt}, m_cfg);
      end
      if (update !== m_upd) begin
        bad++; $display("FAIL R6: update got %b exp %b", update, m_upd);
      end
    end
  end

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    sdata = b;
    wait_n(3);
    sclk = 1'b1;
    wait_n(3);
    sclk = 1'b0;
  endtask

  task automatic burst(input logic [7:0] addr, input logic [55:0] pl, input int nbits);
    sce = 1'b0;
    for (int i = 0; i < 8; i++) pulse_bit(addr[i]);
    wait_n(3);
    sce = 1'b1;
    wait_n(4);
    for (int i = 0; i < nbits; i++) pulse_bit(i < 56 ? pl[i] : 1'b1);
    wait_n(3);
    p_disp = m_disp;
    p_cfg  = m_cfg;
    if (addr == 8'h44 && nbits == 56) begin
      if (pl[55]) p_disp[87:44] = pl[43:0];
      else begin
        p_disp[43:0] = pl[43:0];
        p_cfg = {pl[45], pl[46], pl[47], pl[50], pl[49], pl[48]};
      end
      pend_dly = 3;
    end
    sce = 1'b0;
    wait_n(8);
  endtask

  function automatic logic [55:0] lower_frame(input logic [43:0] d, input logic bu,
      input logic sc, input logic dr, input logic [2:0] pc);
    // pc = {P0,P1,P2}
    return {1'b0, 4'b0, pc[2], pc[1], pc[0], dr, sc, bu, 1'b0, d};
  endfunction

  function automatic logic [55:0] upper_frame(input logic [43:0] d);
    return {1'b1, 11'b0, d};
  endfunction

  initial begin
    wait_n(4);
    check_all("R7");
    rst_n = 1'b1;
    wait_n(3);
    check_all("R7");

    burst(8'h44, lower_frame(44'h5A3C96E1F07, 1'b1, 1'b0, 1'b1, 3'b011), 56);
    check_all("R3");
    check_all("R5");
    burst(8'h44, upper_frame(44'hC0FFEE12345), 56);
    check_all("R4");

    burst(8'h45, lower_frame(44'hFFFFFFFFFFF, 1'b0, 1'b1, 1'b0, 3'b100), 56);
    check_all("R1");
    burst(8'h22, upper_frame(44'h00000000001), 56);
    check_all("R1");

    burst(8'h44, lower_frame(44'h123456789AB, 1'b0, 1'b1, 1'b0, 3'b100), 55);
    check_all("R2");
    burst(8'h44, upper_frame(44'hABCDEF01234), 57);
    check_all("R2");

    burst(8'h44, lower_frame(44'hFFFFFFFFFFF, 1'b1, 1'b1, 1'b1, 3'b111), 56);
    check_all("R5");
    burst(8'h44, upper_frame(44'h55555555555), 56);
    check_all("R4");
    burst(8'h44, lower_frame(44'h00000000000, 1'b0, 1'b0, 1'b0, 3'b000), 56);
    check_all("R3");
    burst(8'h44, lower_frame(44'h80000000001, 1'b0, 1'b1, 1'b0, 3'b001), 56);
    check_all("R6");

    wait_n(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule